// File: doc/BRIEF.md
# Translation Base Register Decoder

This block keeps the supervisor page-table base control register of a core that is 32 or 64 bits wide. The core's control-register write port drives it. Each write is screened: a value that names a translation mode the core cannot run is thrown away whole, so the old contents stay. An accepted value is stored with its address-space identifier bits cleared.

The stored value and the current effective privilege level are decoded, without a clock, into the parameters a page walker needs: the number of table levels, the index width per level, the size of a table entry in bytes, and the physical address of the root table. A flag shows that translation is active, and a second flag shows a privilege or mode combination that has no meaning. The register width is a parameter, chosen when the block is built.

Top module: `xlat_base_reg`

## Requirements
- R1: After reset the register reads as zero, `xlat_on` is 0, and `levels`, `idx_bits`, `pte_bytes` and `root_base` are all 0.
- R2: With XLEN=64, a write is stored when its mode field (bits 63:61) is 0, 4, 5, 6 or 7. The stored value reads back in the cycle after the write edge.
- R3: With XLEN=64, a write whose mode field is 1, 2 or 3 is dropped, and the register keeps its previous value.
- R4: A stored value keeps only the mode field and the page-number field. The page number is bits 37:0 for XLEN=64 and bits 21:0 for XLEN=32. All other bits read back as 0, which includes the address-space identifier.
- R5: With XLEN=64 and privilege 0 (user) or 1 (supervisor), the outputs `levels`/`idx_bits`/`pte_bytes` take these values: mode 4 gives 3/9/8, mode 5 gives 4/9/8, mode 6 gives 5/9/8 and mode 7 gives 6/9/8.
- R6: Mode 0 gives zero for every decoded output, and `xlat_on` is 0.
- R7: Privilege 3 (machine) gives zero for every decoded output, and `xlat_on` is 0, whatever mode is stored.
- R8: While `xlat_on` is 1, `root_base` equals the stored page number shifted left by 12. `xlat_on` is 1 exactly when `levels` is non-zero.
- R9: Privilege 2 (reserved) raises `mode_bad` and gives zero for every decoded output. For privilege 0, 1 or 3, `mode_bad` is 0. A change of privilege takes effect in the same cycle.
- R10: With XLEN=32, bit 31 is the mode and every write is stored. Mode 1 at privilege 0 or 1 gives 2/10/4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | XLEN | Value offered by the write |
| priv | input | 2 | Effective privilege: 0 user, 1 supervisor, 2 reserved, 3 machine |
| rd_data | output | XLEN | Stored register value |
| xlat_on | output | 1 | Translation is active |
| mode_bad | output | 1 | The privilege or mode combination is undefined |
| levels | output | 3 | Number of page-table levels |
| idx_bits | output | 4 | Virtual index bits per level |
| pte_bytes | output | 4 | Table entry size in bytes |
| root_base | output | PPN_W+12 | Physical address of the root table |

## Verification
A write that the register accepts appears on `rd_data` and on every decoded output in the cycle after the edge at which `wr_en` was sampled. The bench drives each write one time unit after an edge and reads the results one time unit after the next edge. A change of `priv` reaches the decoded outputs with no clock, so the bench checks them a short delay after it changes privilege, with no edge in between. The expected register contents and decode results come from bench functions that use the field positions and tables given in the requirements.

// File: rtl/xlat_base_reg.sv
module xlat_base_reg #(
  parameter int XLEN = 64,
  parameter int PAGE_SHIFT = 12,
  localparam int PPN_W = (XLEN == 64) ? 38 : 22,
  localparam int MODE_W = (XLEN == 64) ? 3 : 1,
  localparam int ROOT_W = PPN_W + PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [XLEN-1:0]   wr_data,
  input  logic [1:0]        priv,
  output logic [XLEN-1:0]   rd_data,
  output logic              xlat_on,
  output logic              mode_bad,
  output logic [2:0]        levels,
  output logic [3:0]        idx_bits,
  output logic [3:0]        pte_bytes,
  output logic [ROOT_W-1:0] root_base
);
  localparam int GAP_W = XLEN - MODE_W - PPN_W;

  logic [MODE_W-1:0] mode_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [MODE_W-1:0] wr_mode;
  logic              wr_ok;
  logic [2:0]        mode_code;

  assign wr_mode = wr_data[XLEN-1 -: MODE_W];

  generate
    if (XLEN == 64) begin : g_w64
      assign wr_ok = (wr_mode == '0) || wr_mode[MODE_W-1];
      assign mode_code = mode_q;
    end else begin : g_w32
      assign wr_ok = 1'b1;
      assign mode_code = {2'b00, mode_q};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      ppn_q  <= '0;
    end else if (wr_en && wr_ok) begin
      mode_q <= wr_mode;
      ppn_q  <= wr_data[PPN_W-1:0];
    end
  end

  assign rd_data = {mode_q, {GAP_W{1'b0}}, ppn_q};

  always_comb begin
    levels    = 3'd0;
    idx_bits  = 4'd0;
    pte_bytes = 4'd0;
    mode_bad  = 1'b0;
    if (priv == 2'd2) begin
      mode_bad = 1'b1;
    end else if (priv != 2'd3) begin
      case (mode_code)
        3'd0: ;
        3'd1: begin
          if (XLEN == 32) begin
            levels = 3'd2; idx_bits = 4'd10; pte_bytes = 4'd4;
          end else mode_bad = 1'b1;
        end
        3'd4, 3'd5, 3'd6, 3'd7: begin
          if (XLEN == 64) begin
            levels = mode_code - 3'd1; idx_bits = 4'd9; pte_bytes = 4'd8;
          end else mode_bad = 1'b1;
        end
        default: mode_bad = 1'b1;
      endcase
    end
  end

  assign xlat_on   = (levels != 3'd0);
  assign root_base = xlat_on ? {ppn_q, {PAGE_SHIFT{1'b0}}} : '0;
endmodule

// File: rtl/xlat_base_reg_chk.sv
module xlat_base_reg_chk #(
  parameter int XLEN = 64,
  parameter int ROOT_W = 50
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [XLEN-1:0]   wr_data,
  input logic [1:0]        priv,
  input logic [XLEN-1:0]   rd_data,
  input logic              xlat_on,
  input logic              mode_bad,
  input logic [2:0]        levels,
  input logic [3:0]        idx_bits,
  input logic [3:0]        pte_bytes,
  input logic [ROOT_W-1:0] root_base
);
  localparam int PPN_W = (XLEN == 64) ? 38 : 22;
  localparam int MODE_W = (XLEN == 64) ? 3 : 1;
  localparam logic [XLEN-1:0] KEEP = ~({XLEN{1'b1}} << PPN_W) | ({XLEN{1'b1}} << (XLEN - MODE_W));

  logic [2:0] top3;
  logic       acc;
  assign top3 = wr_data[XLEN-1 -: 3];
  assign acc  = (XLEN != 64) || (top3 == 3'd0) || top3[2];

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc) |=> (rd_data == ($past(wr_data) & KEEP)));
  assert_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !acc) |=> $stable(rd_data));
  assert_asid_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~KEEP) == '0);
  assert_machine_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == 2'd3) |-> (levels == 3'd0 && !xlat_on && root_base == '0));
  assert_on_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_on == (levels != 3'd0));
  assert_root_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_on |-> (root_base == {rd_data[PPN_W-1:0], 12'h000}));
  assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == 2'd2) |-> (mode_bad && levels == 3'd0));
  assert_entry_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_on |-> (pte_bytes == ((XLEN == 64) ? 4'd8 : 4'd4) && idx_bits != 4'd0));
endmodule

bind xlat_base_reg xlat_base_reg_chk #(.XLEN(XLEN), .ROOT_W(ROOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .priv(priv),
  .rd_data(rd_data), .xlat_on(xlat_on), .mode_bad(mode_bad), .levels(levels),
  .idx_bits(idx_bits), .pte_bytes(pte_bytes), .root_base(root_base)
);

// File: tb/xlat_base_reg_bench.sv
`timescale 1ns/1ps
module xlat_base_reg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] priv = 2'd1;
  always #2.5 clk = ~clk;

  logic        we64 = 1'b0, we32 = 1'b0;
  logic [63:0] wd64 = '0, rd64;
  logic [31:0] wd32 = '0, rd32;
  logic        on64, bad64, on32, bad32;
  logic [2:0]  lv64, lv32;
  logic [3:0]  ib64, pb64, ib32, pb32;
  logic [49:0] rb64;
  logic [33:0] rb32;

  xlat_base_reg #(.XLEN(64)) u_xlat_base_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(we64), .wr_data(wd64), .priv(priv),
    .rd_data(rd64), .xlat_on(on64), .mode_bad(bad64), .levels(lv64),
    .idx_bits(ib64), .pte_bytes(pb64), .root_base(rb64));

  xlat_base_reg #(.XLEN(32)) u_xlat_base_reg_w32 (
    .clk(clk), .rst_n(rst_n), .wr_en(we32), .wr_data(wd32), .priv(priv),
    .rd_data(rd32), .xlat_on(on32), .mode_bad(bad32), .levels(lv32),
    .idx_bits(ib32), .pte_bytes(pb32), .root_base(rb32));

  int total = 0, bad = 0;
  logic [63:0] m64 = '0;
  logic [31:0] m32 = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] next64(input logic [63:0] old, input logic [63:0] d);
    if (d[63:61] == 3'd0 || d[63]) return {d[63:61], 23'd0, d[37:0]};
    return old;
  endfunction

  // {bad, levels, idx, bytes}
  function automatic logic [11:0] dec64(input logic [2:0] m, input logic [1:0] p);
    if (p == 2'd2) return 12'h800;
    if (p == 2'd3 || m == 3'd0) return 12'h000;
    if (m >= 3'd4) return {1'b0, m - 3'd1, 4'd9, 4'd8};
    return 12'h800;
  endfunction

  function automatic logic [11:0] dec32(input logic m, input logic [1:0] p);
    if (p == 2'd2) return 12'h800;
    if (p == 2'd3 || !m) return 12'h000;
    return {1'b0, 3'd2, 4'd10, 4'd4};
  endfunction

  task automatic check_out(input string tag);
    logic [11:0] e64, e32;
    e64 = dec64(m64[63:61], priv);
    e32 = dec32(m32[31], priv);
    chk({tag, " R4 rd64"}, rd64, m64);
    chk({tag, " R5 dec64"}, {52'd0, bad64, lv64, ib64, pb64}, {52'd0, e64});
    chk({tag, " R8 on64"}, {63'd0, on64}, {63'd0, e64[10:8] != 3'd0});
    chk({tag, " R8 root64"}, {14'd0, rb64}, (e64[10:8] != 3'd0) ? {14'd0, m64[37:0], 12'h000} : 64'd0);
    chk({tag, " R10 rd32"}, {32'd0, rd32}, {32'd0, m32});
    chk({tag, " R10 dec32"}, {52'd0, bad32, lv32, ib32, pb32}, {52'd0, e32});
    chk({tag, " R8 root32"}, {30'd0, rb32}, (e32[10:8] != 3'd0) ? {30'd0, m32[21:0], 12'h000} : 64'd0);
  endtask

  task automatic wr(input logic [63:0] d64, input logic [31:0] d32);
    @(posedge clk); #1;
    we64 = 1'b1; wd64 = d64; we32 = 1'b1; wd32 = d32;
    @(posedge clk); #1;
    we64 = 1'b0; we32 = 1'b0;
    m64 = next64(m64, d64);
    m32 = {d32[31], 9'd0, d32[21:0]};
  endtask

  bit done = 0;
  initial begin
    #(200000 * 5.0);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 check_out("R1 reset");
    chk("R1 on after reset", {62'd0, on64, on32}, 64'd0);

    // R5 every 64-bit mode, R2 accepted
    for (int m = 4; m < 8; m++) begin
      wr({3'(m), 23'h7fffff, 38'h12_3456_789a}, 32'hffc0_0abc);
      check_out("R2 R5 mode");
    end
    // R3 dropped modes
    for (int m = 1; m < 4; m++) begin
      wr({3'(m), 61'h1f_ffff_ffff}, 32'h0000_0001);
      check_out("R3 drop");
    end
    // R6 off
    wr(64'h1fff_ffff_ffff_ffff, 32'h7fff_ffff);
    check_out("R6 off");
    // R7 machine, R9 reserved, same-cycle privilege effect
    wr({3'd5, 61'h0000_0000_0000_abcd}, 32'h8000_1234);
    priv = 2'd3; #1 check_out("R7 machine");
    priv = 2'd2; #1 check_out("R9 reserved");
    chk("R9 bad flags", {62'd0, bad64, bad32}, 64'd3);
    priv = 2'd0; #1 check_out("R9 user");
    chk("R9 bad clear", {62'd0, bad64, bad32}, 64'd0);
    priv = 2'd1;
    // random
    for (int i = 0; i < 300; i++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      priv = 2'($urandom_range(0, 3));
      wr(d, $urandom);
      check_out("R2 R3 R10 random");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule